// File: doc/BRIEF.md
# Paired Register Stage with Configurable Set/Reset

This block models the storage stage at the output of a logic cell: two bits of state that share one clock, one clock enable and one set/reset control group, while each bit keeps its own data source, storage style, forced level and start-up value. Each bit is built either as an edge-triggered flip-flop or as a level-sensitive latch. Its data comes either from the function-generator result or from a direct bypass input.

The shared controls each pass through their own polarity inverter before use. The set/reset input drives each bit to its own configured level. A second force input drives the opposite level, and it is honoured only while set/reset is enabled. When both forces are active, the result is a 0. The pair can apply these forces synchronously, at the active clock edge and without regard to the clock enable, or asynchronously, the moment they become active. A global initialisation input overrides everything else and loads each bit's start-up value without waiting for a clock. That value follows the bit's forced level unless the bit is given an independent value. Configuration inputs are static; they are changed only while global initialisation is held.

Top module: `regPairStage`

## Requirements
- R1: While `gInitIn` is 1, every `qOut` bit equals its start-up value, regardless of all other inputs and without waiting for a clock. The start-up value is `cfgInitVal[e]` when `cfgInitOwn[e]` is 1; otherwise it is `cfgSrHigh[e]`.
- R2: A bit in flip-flop mode (`cfgLatchMode[e]`=0) loads its selected data at the active clock edge when the effective enable is 1, and holds between edges.
- R3: `cfgSelBypass[e]`=1 selects `bypIn[e]` as data; 0 selects `fgIn[e]`.
- R4: A bit in latch mode follows its selected data while the effective clock is 1 and the effective enable is 1, and holds while the effective clock is 0.
- R5: The effective enable is `ceIn ^ cfgInvCe` when `cfgCeUsed` is 1 and is constantly 1 when `cfgCeUsed` is 0. With the effective enable at 0 and no force, a bit holds at the edge.
- R6: An active set/reset (`srIn ^ cfgInvSr` = 1, with `cfgSrUsed`=1) drives bit e to `cfgSrHigh[e]`.
- R7: An active opposite force (`revIn ^ cfgInvRev` = 1, with `cfgSrUsed`=1) drives bit e to the inverse of `cfgSrHigh[e]`. With `cfgSrUsed`=0, both `srIn` and `revIn` have no effect.
- R8: With set/reset and the opposite force both active, every bit is driven to 0.
- R9: With `cfgSrAsync`=1, forces act as soon as they are active. With `cfgSrAsync`=0, they act only at an active clock edge (a flip-flop) or while the gate is open (a latch), and in both cases they ignore the enable.
- R10: The effective clock is `clkIn ^ cfgInvClk`, so with inversion a flip-flop loads on the falling edge of `clkIn`.
- R11: Set/reset polarity inversion (`cfgInvSr`=1) makes a 0 on `srIn` the active level.
- R12: Clock, enable and force controls are common to both bits, while mode, data source, forced level and start-up value are set per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Shared clock before polarity selection |
| gInitIn | input | 1 | Global initialisation, active high, asynchronous |
| ceIn | input | 1 | Shared clock enable before polarity selection |
| srIn | input | 1 | Shared set/reset force before polarity selection |
| revIn | input | 1 | Shared opposite-level force before polarity selection |
| fgIn | input | NUM_ELEM | Function-generator result per bit |
| bypIn | input | NUM_ELEM | Bypass data per bit |
| cfgInvClk | input | 1 | Invert clock |
| cfgInvCe | input | 1 | Invert clock enable |
| cfgInvSr | input | 1 | Invert set/reset |
| cfgInvRev | input | 1 | Invert opposite force |
| cfgCeUsed | input | 1 | 0 ties the enable active |
| cfgSrUsed | input | 1 | 1 enables both forces |
| cfgSrAsync | input | 1 | 1 makes forces asynchronous |
| cfgLatchMode | input | NUM_ELEM | 1 makes the bit a latch |
| cfgSelBypass | input | NUM_ELEM | 1 selects bypass data |
| cfgSrHigh | input | NUM_ELEM | Level forced by set/reset |
| cfgInitOwn | input | NUM_ELEM | 1 uses the independent start-up value |
| cfgInitVal | input | NUM_ELEM | Independent start-up value |
| qOut | output | NUM_ELEM | Stored bits |

## Verification
The hardest situations to reach are the handovers between asynchronous sources while one of them stays active. Examples are global initialisation releasing while a force is already active, and the opposite force joining or leaving an active set/reset, where the forced level flips with no clock edge. Random stimulus holds forces active across initialisation pulses and toggles the two forces independently in asynchronous mode. A reference model is evaluated at each drive point and at each clock phase, so every transition is checked both between edges and after them, under both clock polarities.

// File: rtl/regPairPkg.sv
package regPairPkg;

  // Strobes the control decoder hands to every storage cell.
  typedef struct packed {
    logic clkEff;     // clock after polarity selection
    logic ceAct;      // enable after polarity / tie-off
    logic srAct;      // set/reset force active
    logic revAct;     // opposite-level force active
    logic asyncMode;  // forces act without a clock
    logic ginit;      // global initialisation
  } ctrlStrobe_t;

  // Level a forced bit settles to; a pair of active forces resolves to 0.
  function automatic logic forcedLevel(input logic srAct, input logic revAct,
                                       input logic srHigh);
    if (srAct && revAct) return 1'b0;
    if (srAct) return srHigh;
    return ~srHigh;
  endfunction

endpackage

// File: rtl/regPairCtrl.sv
module regPairCtrl
  import regPairPkg::*;
(
  input  logic        clkIn,
  input  logic        gInitIn,
  input  logic        ceIn,
  input  logic        srIn,
  input  logic        revIn,
  input  logic        cfgInvClk,
  input  logic        cfgInvCe,
  input  logic        cfgInvSr,
  input  logic        cfgInvRev,
  input  logic        cfgCeUsed,
  input  logic        cfgSrUsed,
  input  logic        cfgSrAsync,
  output ctrlStrobe_t strobe
);

  // All strobes are produced together so that simultaneous input changes
  // reach the cells in one update.
  always_comb begin
    strobe.clkEff    = clkIn ^ cfgInvClk;
    strobe.ceAct     = cfgCeUsed ? (ceIn ^ cfgInvCe) : 1'b1;
    strobe.srAct     = cfgSrUsed & (srIn ^ cfgInvSr);
    strobe.revAct    = cfgSrUsed & (revIn ^ cfgInvRev);
    strobe.asyncMode = cfgSrAsync;
    strobe.ginit     = gInitIn;
  end

endmodule

// File: rtl/regPairCell.sv
module regPairCell
  import regPairPkg::*;
(
  input  ctrlStrobe_t strobe,
  input  logic        fgIn,
  input  logic        bypIn,
  input  logic        cfgLatchMode,
  input  logic        cfgSelBypass,
  input  logic        cfgSrHigh,
  input  logic        cfgInitOwn,
  input  logic        cfgInitVal,
  output logic        qOut
);

  logic gateClk;
  logic dSel;
  logic forceAct;
  logic forceVal;
  logic initVal;
  logic asyncForce;
  logic syncForce;
  logic rstLine;
  logic setLine;
  logic qFlop;
  logic qLatch;

  assign gateClk = strobe.clkEff;

  always_comb begin
    dSel       = cfgSelBypass ? bypIn : fgIn;
    forceAct   = strobe.srAct | strobe.revAct;
    forceVal   = forcedLevel(strobe.srAct, strobe.revAct, cfgSrHigh);
    initVal    = cfgInitOwn ? cfgInitVal : cfgSrHigh;
    asyncForce = strobe.asyncMode & forceAct;
    syncForce  = ~strobe.asyncMode & forceAct;
    // Asynchronous sources are split into one clear line and one preset
    // line that are never high together; every change of the wanted level
    // shows up as a rising edge on one of them.
    rstLine    = strobe.ginit ? ~initVal : (asyncForce & ~forceVal);
    setLine    = strobe.ginit ?  initVal : (asyncForce &  forceVal);
  end

  // Edge-triggered variant.
  always_ff @(posedge gateClk or posedge rstLine or posedge setLine) begin
    if (rstLine)        qFlop <= 1'b0;
    else if (setLine)   qFlop <= 1'b1;
    else if (syncForce) qFlop <= forceVal;
    else if (strobe.ceAct) qFlop <= dSel;
  end

  // Level-sensitive variant.
  always_latch begin
    if (rstLine)        qLatch <= 1'b0;
    else if (setLine)   qLatch <= 1'b1;
    else if (gateClk) begin
      if (syncForce)          qLatch <= forceVal;
      else if (strobe.ceAct)  qLatch <= dSel;
    end
  end

  assign qOut = cfgLatchMode ? qLatch : qFlop;

  // R1
  init_load_chk: assert property (@(posedge gateClk)
    strobe.ginit |-> (qOut == initVal));

  // R9
  async_force_chk: assert property (@(posedge gateClk) disable iff (strobe.ginit)
    asyncForce |-> (qOut == forceVal));

  // R8
  force_prio_chk: assert property (@(posedge gateClk) disable iff (strobe.ginit)
    (strobe.asyncMode && strobe.srAct && strobe.revAct) |-> (qOut == 1'b0));

  // R9
  sync_force_chk: assert property (@(posedge gateClk) disable iff (strobe.ginit)
    (!cfgLatchMode && syncForce) |=> (qOut == $past(forceVal)));

  // R2
  capture_chk: assert property (@(posedge gateClk) disable iff (strobe.ginit)
    (!cfgLatchMode && !forceAct && strobe.ceAct)
      |=> ((qOut == $past(dSel)) || asyncForce));

  // R5
  hold_chk: assert property (@(posedge gateClk) disable iff (strobe.ginit)
    (!cfgLatchMode && !strobe.asyncMode && !forceAct && !strobe.ceAct)
      |=> $stable(qOut));

endmodule

// File: rtl/regPairDatapath.sv
module regPairDatapath
  import regPairPkg::*;
#(
  parameter int NUM_ELEM = 2
) (
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_ELEM-1:0] fgIn,
  input  logic [NUM_ELEM-1:0] bypIn,
  input  logic [NUM_ELEM-1:0] cfgLatchMode,
  input  logic [NUM_ELEM-1:0] cfgSelBypass,
  input  logic [NUM_ELEM-1:0] cfgSrHigh,
  input  logic [NUM_ELEM-1:0] cfgInitOwn,
  input  logic [NUM_ELEM-1:0] cfgInitVal,
  output logic [NUM_ELEM-1:0] qOut
);

  for (genvar e = 0; e < NUM_ELEM; e++) begin : gCell
    regPairCell uCell (
      .strobe       (strobe),
      .fgIn         (fgIn[e]),
      .bypIn        (bypIn[e]),
      .cfgLatchMode (cfgLatchMode[e]),
      .cfgSelBypass (cfgSelBypass[e]),
      .cfgSrHigh    (cfgSrHigh[e]),
      .cfgInitOwn   (cfgInitOwn[e]),
      .cfgInitVal   (cfgInitVal[e]),
      .qOut         (qOut[e])
    );
  end

endmodule

// File: rtl/regPairStage.sv
module regPairStage
  import regPairPkg::*;
#(
  parameter int NUM_ELEM = 2
) (
  input  logic                clkIn,
  input  logic                gInitIn,
  input  logic                ceIn,
  input  logic                srIn,
  input  logic                revIn,
  input  logic [NUM_ELEM-1:0] fgIn,
  input  logic [NUM_ELEM-1:0] bypIn,
  input  logic                cfgInvClk,
  input  logic                cfgInvCe,
  input  logic                cfgInvSr,
  input  logic                cfgInvRev,
  input  logic                cfgCeUsed,
  input  logic                cfgSrUsed,
  input  logic                cfgSrAsync,
  input  logic [NUM_ELEM-1:0] cfgLatchMode,
  input  logic [NUM_ELEM-1:0] cfgSelBypass,
  input  logic [NUM_ELEM-1:0] cfgSrHigh,
  input  logic [NUM_ELEM-1:0] cfgInitOwn,
  input  logic [NUM_ELEM-1:0] cfgInitVal,
  output logic [NUM_ELEM-1:0] qOut
);

  ctrlStrobe_t strobe;

  regPairCtrl uCtrl (
    .clkIn      (clkIn),
    .gInitIn    (gInitIn),
    .ceIn       (ceIn),
    .srIn       (srIn),
    .revIn      (revIn),
    .cfgInvClk  (cfgInvClk),
    .cfgInvCe   (cfgInvCe),
    .cfgInvSr   (cfgInvSr),
    .cfgInvRev  (cfgInvRev),
    .cfgCeUsed  (cfgCeUsed),
    .cfgSrUsed  (cfgSrUsed),
    .cfgSrAsync (cfgSrAsync),
    .strobe     (strobe)
  );

  regPairDatapath #(.NUM_ELEM(NUM_ELEM)) uData (
    .strobe       (strobe),
    .fgIn         (fgIn),
    .bypIn        (bypIn),
    .cfgLatchMode (cfgLatchMode),
    .cfgSelBypass (cfgSelBypass),
    .cfgSrHigh    (cfgSrHigh),
    .cfgInitOwn   (cfgInitOwn),
    .cfgInitVal   (cfgInitVal),
    .qOut         (qOut)
  );

endmodule

// File: tb/tb_regPairStage.sv
`timescale 1ns/100ps
module tb_regPairStage;
  localparam int N = 2;

  logic clkIn = 1'b0;
  always #2 clkIn = ~clkIn;  // 250 MHz

  logic gInitIn, ceIn, srIn, revIn;
  logic [N-1:0] fgIn, bypIn;
  logic cfgInvClk, cfgInvCe, cfgInvSr, cfgInvRev, cfgCeUsed, cfgSrUsed, cfgSrAsync;
  logic [N-1:0] cfgLatchMode, cfgSelBypass, cfgSrHigh, cfgInitOwn, cfgInitVal;
  logic [N-1:0] qOut;

  // Pending configuration, loaded only while initialisation is held.
  logic [6:0]   nxtShared;
  logic [N-1:0] nxtLatch, nxtSel, nxtHigh, nxtOwn, nxtVal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [N-1:0] mq;
  string mtag [N];

  regPairStage #(.NUM_ELEM(N)) dut (.*);

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      finishRun();
    end
  end

  // Reference model: applies the rules in priority order.
  task automatic modelEval(input logic rising, input logic level);
    logic ceA, srA, rvA, fv, dd;
    ceA = !cfgCeUsed || (ceIn ^ cfgInvCe);
    srA = cfgSrUsed && (srIn ^ cfgInvSr);
    rvA = cfgSrUsed && (revIn ^ cfgInvRev);
    for (int e = 0; e < N; e++) begin
      fv = (srA && rvA) ? 1'b0 : (srA ? cfgSrHigh[e] : !cfgSrHigh[e]);
      dd = cfgSelBypass[e] ? bypIn[e] : fgIn[e];
      if (gInitIn) begin
        mq[e] = cfgInitOwn[e] ? cfgInitVal[e] : cfgSrHigh[e];
        mtag[e] = "R1";
      end else if (cfgSrAsync && (srA || rvA)) begin
        mq[e] = fv;
        mtag[e] = (srA && rvA) ? "R8" : (rvA ? "R7" : (cfgInvSr ? "R11" : "R6"));
      end else if (cfgLatchMode[e]) begin
        if (level) begin
          if (srA || rvA) begin mq[e] = fv; mtag[e] = "R9"; end
          else if (ceA) begin mq[e] = dd; mtag[e] = "R4"; end
          else mtag[e] = "R5";
        end
      end else if (rising) begin
        if (srA || rvA) begin mq[e] = fv; mtag[e] = "R9"; end
        else if (ceA) begin
          mq[e] = dd;
          mtag[e] = cfgInvClk ? "R10" : (cfgSelBypass[e] ? "R3" : "R2");
        end else mtag[e] = "R5";
      end
    end
  endtask

  task automatic checkOut();
    checks++;
    if (qOut !== mq) begin
      fails++;
      for (int e = 0; e < N; e++)
        if (qOut[e] !== mq[e]) begin
          $display("FAIL %s bit %0d actual=%b expected=%b (q actual=%b expected=%b)",
                   mtag[e], e, qOut[e], mq[e], qOut, mq);
          break;
        end
    end
  endtask

  task automatic checkLit(input logic [N-1:0] exp, input string tag);
    checks++;
    if (qOut !== exp) begin
      fails++;
      $display("FAIL %s directed actual=%b expected=%b", tag, qOut, exp);
    end
  endtask

  // One clock period: drive, settle, both edges, with a check after each.
  task automatic runStep(input logic gi, input logic ce, input logic sr,
                         input logic rv, input logic [N-1:0] fg,
                         input logic [N-1:0] byp, input bit loadCfg);
    #0.5;
    gInitIn = gi; ceIn = ce; srIn = sr; revIn = rv; fgIn = fg; bypIn = byp;
    if (loadCfg) begin
      {cfgInvClk, cfgInvCe, cfgInvSr, cfgInvRev, cfgCeUsed, cfgSrUsed, cfgSrAsync} = nxtShared;
      cfgLatchMode = nxtLatch; cfgSelBypass = nxtSel; cfgSrHigh = nxtHigh;
      cfgInitOwn = nxtOwn; cfgInitVal = nxtVal;
    end
    modelEval(1'b0, !cfgInvClk);
    #0.5; checkOut();
    @(negedge clkIn);
    modelEval(cfgInvClk, cfgInvClk);
    #1; checkOut();
    @(posedge clkIn);
    modelEval(!cfgInvClk, !cfgInvClk);
    #0.5; checkOut();
  endtask

  task automatic reconfigure();
    runStep(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
    runStep(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    gInitIn = 1'b1; ceIn = 0; srIn = 0; revIn = 0; fgIn = '0; bypIn = '0;
    {cfgInvClk, cfgInvCe, cfgInvSr, cfgInvRev, cfgCeUsed, cfgSrUsed, cfgSrAsync} = 7'b0000111;
    cfgLatchMode = '0; cfgSelBypass = '0;
    cfgSrHigh = 2'b01; cfgInitOwn = 2'b10; cfgInitVal = 2'b00;
    mq = '0;
    for (int e = 0; e < N; e++) mtag[e] = "R1";
    @(posedge clkIn);

    // R1 reset state: bit0 follows its forced level 1, bit1 own value 0.
    runStep(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
    checkLit(2'b01, "R1");

    // R12 asynchronous forces act on both bits with per-bit levels.
    runStep(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
    checkLit(2'b01, "R12");
    runStep(1'b0, 1'b0, 1'b0, 1'b1, '0, '0, 1'b0);
    checkLit(2'b10, "R7");
    runStep(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, 1'b0);
    checkLit(2'b00, "R8");

    // R5 enable tied active while ceIn is 0: flip-flops still load.
    nxtShared = 7'b0000011; nxtLatch = '0; nxtSel = 2'b10; nxtHigh = '0;
    nxtOwn = '0; nxtVal = '0;
    reconfigure();
    runStep(1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'b10, 1'b0);
    checkLit(2'b11, "R5");

    // R7 with forces disabled, set/reset and opposite force are ignored.
    nxtShared = 7'b0000101;
    reconfigure();
    runStep(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 2'b11, 1'b0);
    checkLit(2'b11, "R7");
    runStep(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0);
    checkLit(2'b11, "R7");

    // R11 inverted set/reset polarity: 0 on srIn forces, async.
    nxtShared = 7'b0010011; nxtHigh = 2'b11;
    reconfigure();
    runStep(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0);
    checkLit(2'b00, "R11");
    runStep(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0);
    checkLit(2'b11, "R11");

    // Random configurations and stimulus, checked against the model.
    for (int c = 0; c < 40; c++) begin
      nxtShared = 7'($urandom);
      nxtLatch = N'($urandom); nxtSel = N'($urandom); nxtHigh = N'($urandom);
      nxtOwn = N'($urandom); nxtVal = N'($urandom);
      reconfigure();
      for (int s = 0; s < 40; s++) begin
        logic gi, ce, sr, rv;
        gi = (($urandom % 24) == 0);
        ce = $urandom;
        sr = (($urandom % 4) == 0) ^ nxtShared[4];
        rv = (($urandom % 5) == 0) ^ nxtShared[3];
        runStep(gi, ce, sr, rv, N'($urandom), N'($urandom), 1'b0);
      end
    end

    finishRun();
  end

endmodule